// File: doc/BRIEF.md
# Seeded Pseudorandom Sequence Generator with Shared Data Bus

This block produces a repeatable pseudorandom sequence from a linear-feedback shift register. On every clock edge that is not a reset or a load, the register moves one position toward its least significant end. The XOR of two fixed tap bits fills the freed top bit. A given starting value always yields the same sequence.

The register connects to the outside world through a single bidirectional bus. When the output enable is high, the block drives its current state onto the bus. When the load strobe is high, the block releases the bus and takes the value on it as the new seed, so a host can replace the state at any time. An all-zero seed would freeze the register, so the block replaces it with the default seed.

Top module: `seeded_lfsr_bus`

## Requirements
- R1: While the active-low synchronous reset `rst_n` is low at a rising clock edge, the register becomes the default seed 7'b0000001.
- R2: With the default 7-bit width, each non-reset, non-load edge moves state `q` to `{q[0]^q[1], q[6:1]}`.
- R3: The next-state rule in R2 holds for every step, with nothing else changing the register.
- R4: From any nonzero state, the state returns to itself after exactly 127 steps and not after fewer.
- R5: When `load_i` is high and `rst_n` is high, the register takes the nonzero bus value at that edge, and no shift happens in that cycle.
- R6: A load of the all-zero value sets the register to 7'b0000001, and the register never holds zero.
- R7: The block drives `data_io` with `q` only when `oe_i` is high and `load_i` is low. Otherwise it leaves the bus undriven, so an external value placed on the bus reads back unchanged. `oe_i` has no effect while `load_i` is high.
- R8: Reset takes priority over load: if both are active at one edge, the register takes the default seed.
- R9: Loading the same seed twice gives the same following sequence both times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset to the default seed |
| load_i | input | 1 | Load strobe; takes the seed from the bus and releases the bus |
| oe_i | input | 1 | Output enable; drives the state onto the bus when not loading |
| data_io | inout | 7 | Shared bidirectional data bus |

## Verification
Two pairs of functions can collide in one cycle. The first is a load with the output enable still high. The bench raises both together, drives its own seed, and expects that seed to read back on the bus unchanged during the cycle and to be held in the register afterwards. The second is a reset together with a load. The bench raises both at the same edge and expects the default seed rather than the bus value.

// File: rtl/lfsr_pkg.sv
// Shared width, tap positions and state type for the seeded generator.
// Assumes the two taps differ and both lie inside the register.
package lfsr_pkg;
    localparam int unsigned LFSR_W   = 7;
    localparam int unsigned TAP_LO   = 0;
    localparam int unsigned TAP_HI   = 1;
    localparam logic [LFSR_W-1:0] SEED_DEFAULT = 7'b0000001;

    typedef logic [LFSR_W-1:0] lfsr_state_t;

    typedef enum logic [1:0] {
        OP_RESET = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } lfsr_op_e;
endpackage

// File: rtl/lfsr_step.sv
// Combinational next-state logic: one right shift with a two-tap XOR
// into the top bit. Assumes W >= 2 and that TA and TB are distinct valid indices.
module lfsr_step #(
    parameter int unsigned W  = 7,
    parameter int unsigned TA = 0,
    parameter int unsigned TB = 1
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);
    logic fb;

    // feedback bit from the two taps
    assign fb = cur_i[TA] ^ cur_i[TB];

    // shifted body: every bit takes its upper neighbour
    for (genvar i = 0; i < W - 1; i++) begin : g_shift
        assign nxt_o[i] = cur_i[i+1];
    end
    assign nxt_o[W-1] = fb;
endmodule

// File: rtl/lfsr_bus_port.sv
// Direction control for the shared bus. Decides when the block may drive
// and cleans the incoming seed: an all-zero value becomes the default seed.
// Assumes the top level owns the actual three-state driver.
module lfsr_bus_port #(
    parameter int unsigned W = 7,
    parameter logic [W-1:0] SEED = 1
) (
    input  logic         load_i,
    input  logic         oe_i,
    input  logic [W-1:0] bus_in_i,
    output logic         drive_en_o,
    output logic [W-1:0] seed_o
);
    // drive only when reading and never while taking a seed
    assign drive_en_o = oe_i & ~load_i;

    // substitute the default for a lock-up value
    always_comb begin
        if (bus_in_i == '0) seed_o = SEED;
        else                seed_o = bus_in_i;
    end
endmodule

// File: rtl/lfsr_core.sv
// State register with priority reset > load > shift.
// Synchronous active-low reset. Assumes seed_i is never zero.
module lfsr_core
    import lfsr_pkg::*;
#(
    parameter int unsigned W  = 7,
    parameter int unsigned TA = 0,
    parameter int unsigned TB = 1,
    parameter logic [W-1:0] SEED = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_r;
    logic [W-1:0] q_step;
    lfsr_op_e     op;

    lfsr_step #(.W(W), .TA(TA), .TB(TB)) u_step (
        .cur_i (q_r),
        .nxt_o (q_step)
    );

    // select this cycle's operation by priority
    always_comb begin
        if (!rst_n)      op = OP_RESET;
        else if (load_i) op = OP_LOAD;
        else             op = OP_SHIFT;
    end

    // update the state register
    always_ff @(posedge clk) begin
        case (op)
            OP_RESET: q_r <= SEED;
            OP_LOAD:  q_r <= seed_i;
            default:  q_r <= q_step;
        endcase
    end

    assign q_o = q_r;
endmodule

// File: rtl/seeded_lfsr_bus.sv
// Top level: seeded pseudorandom generator on one bidirectional bus.
// Drives the state out when enabled and takes a seed in on load.
// Assumes the external side releases the bus whenever oe_i is high without load_i.
module seeded_lfsr_bus
    import lfsr_pkg::*;
#(
    parameter int unsigned W  = LFSR_W,
    parameter int unsigned TA = TAP_LO,
    parameter int unsigned TB = TAP_HI,
    parameter logic [W-1:0] SEED = SEED_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         oe_i,
    inout  wire  [W-1:0] data_io
);
    logic [W-1:0] bus_in;
    logic [W-1:0] seed_clean;
    logic [W-1:0] q;
    logic         drive_en;

    // sample the bus for the input path
    assign bus_in = data_io;

    lfsr_bus_port #(.W(W), .SEED(SEED)) u_port (
        .load_i     (load_i),
        .oe_i       (oe_i),
        .bus_in_i   (bus_in),
        .drive_en_o (drive_en),
        .seed_o     (seed_clean)
    );

    lfsr_core #(.W(W), .TA(TA), .TB(TB), .SEED(SEED)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .seed_i (seed_clean),
        .q_o    (q)
    );

    // three-state output driver
    assign data_io = drive_en ? q : {W{1'bz}};
endmodule

// File: rtl/seeded_lfsr_bus_chk.sv
// Checker for seeded_lfsr_bus, attached with bind.
module seeded_lfsr_bus_chk #(
    parameter int unsigned W  = 7,
    parameter int unsigned TA = 0,
    parameter int unsigned TB = 1,
    parameter logic [W-1:0] SEED = 1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load_i,
    input logic [W-1:0] bus_in,
    input logic [W-1:0] q,
    input logic         drive_en
);
    // R1: first cycle after reset shows the default seed
    p_seed_r1: assert property (@(posedge clk) $rose(rst_n) |-> q == SEED);

    // R3: a plain step shifts right with the two-tap feedback
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> q == {$past(q[TA] ^ q[TB]), $past(q[W-1:1])});

    // R5: a nonzero bus value is captured on load
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && bus_in != '0) |=> q == $past(bus_in));

    // R6: a zero load becomes the default seed
    p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && bus_in == '0) |=> q == SEED);

    // R6: the register never holds zero once out of reset
    p_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> q != '0);

    // R7: the block never drives while taking a seed
    p_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !drive_en);
endmodule

bind seeded_lfsr_bus seeded_lfsr_bus_chk #(.W(W), .TA(TA), .TB(TB), .SEED(SEED)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .bus_in   (bus_in),
    .q        (q),
    .drive_en (drive_en)
);

// File: tb/seeded_lfsr_bus_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module seeded_lfsr_bus_tb_top;
    localparam int  W = 7;
    localparam time CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic         oe_i = 1'b0;
    logic         tb_en = 1'b0;
    logic [W-1:0] tb_val = '0;
    wire  [W-1:0] data_io;

    int n_run = 0;
    int n_fail = 0;

    assign data_io = tb_en ? tb_val : {W{1'bz}};

    seeded_lfsr_bus dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .oe_i    (oe_i),
        .data_io (data_io)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] model_step(input logic [W-1:0] v);
        return {v[0] ^ v[1], v[W-1:1]};
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // one clock edge, then settle at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // load a seed through the bus, then hand the bus back to the block
    task automatic load_seed(input logic [W-1:0] s);
        tb_en = 1'b1; tb_val = s; load_i = 1'b1;
        tick();
        load_i = 1'b0; tb_en = 1'b0; oe_i = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; oe_i = 1'b1;
        tick(); tick();
        rst_n = 1'b1; #1;
        check("R1 reset seed", data_io, 7'b0000001);
    endtask

    task automatic t_steps();
        logic [W-1:0] exp;
        exp = data_io;
        for (int i = 0; i < 20; i++) begin
            exp = model_step(exp);
            tick();
            check(i < 10 ? "R2 step" : "R3 step", data_io, exp);
        end
    endtask

    task automatic t_period();
        logic [W-1:0] start;
        int early;
        start = 7'b0101101;
        load_seed(start);
        early = 0;
        for (int i = 1; i < 127; i++) begin
            tick();
            if (data_io == start) early++;
        end
        n_run++;
        if (early != 0) begin
            n_fail++;
            $display("FAIL R4 early repeat actual=%0d expected=0", early);
        end
        tick();
        check("R4 period 127", data_io, start);
    endtask

    task automatic t_load();
        load_seed(7'b1010101);
        check("R5 loaded value", data_io, 7'b1010101);
        tick();
        check("R5 step after load", data_io, model_step(7'b1010101));
    endtask

    task automatic t_zero();
        load_seed('0);
        check("R6 zero load", data_io, 7'b0000001);
    endtask

    task automatic t_bus_release();
        oe_i = 1'b0; tb_en = 1'b1; tb_val = 7'b0110011; #1;
        check("R7 bus free when disabled", data_io, 7'b0110011);
        tb_en = 1'b0; oe_i = 1'b1;
        // oe high during load: block must not drive, and load wins
        tb_en = 1'b1; tb_val = 7'b1100110; load_i = 1'b1; #1;
        check("R7 bus free during load", data_io, 7'b1100110);
        tick();
        load_i = 1'b0; tb_en = 1'b0; #1;
        check("R7 load with oe high", data_io, 7'b1100110);
    endtask

    task automatic t_reset_vs_load();
        tb_en = 1'b1; tb_val = 7'b1111000; load_i = 1'b1; rst_n = 1'b0;
        tick();
        rst_n = 1'b1; load_i = 1'b0; tb_en = 1'b0; oe_i = 1'b1; #1;
        check("R8 reset over load", data_io, 7'b0000001);
    endtask

    task automatic t_repeat();
        logic [W-1:0] first [20];
        load_seed(7'b0011100);
        for (int i = 0; i < 20; i++) begin first[i] = data_io; tick(); end
        for (int i = 0; i < 5; i++) tick();
        load_seed(7'b0011100);
        for (int i = 0; i < 20; i++) begin
            check("R9 same seed same sequence", data_io, first[i]);
            tick();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_steps();
        t_period();
        t_load();
        t_zero();
        t_bus_release();
        t_reset_vs_load();
        t_repeat();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule